// File: doc/BRIEF.md
# Embedded-Clock Word Aligner and Lock Detector

This block sits behind a serial receiver that already delivers one recovered bit per bit-enable pulse. The line carries twelve-bit frames: a high start bit, ten payload bits sent D0 first, and a low stop bit. The low stop bit followed at once by the next high start bit is the only mark of where words begin. The aligner keeps a free-running bit phase modulo twelve. For every phase it counts how many words in a row showed a low-to-high step at that phase. It declares lock only when exactly one phase has held that step for four words running. This rejects data whose repeating transitions look like several frame edges at once.

Once locked, the block watches only the locked phase. Each time the boundary appears there, it presents the word that just ended on a ten-bit output with a one-cycle strobe. Four misses in a row drop the lock and restart the search from clean counters. A receive output enable gates the data path without disturbing lock tracking. An active-low power-down clears the whole block and keeps it idle. The high-impedance state of a pin-level receiver is modelled by an output-enable status flag, with the data and strobe held at zero while it is low.

Top module: `embedded_word_aligner`

## Requirements
- R1: A serial bit is taken only on a cycle with `bit_en` high. Each taken bit advances a bit phase that wraps from 11 to 0, and the phase is 0 for the first bit taken after reset or power-down.
- R2: A hit at a phase means the bit taken there is 1 and the bit taken just before it is 0. Lock is declared on the bit at phase 11 when exactly one phase has had a hit in each of the last four words. After four words of the training word (D0..D4 = 1, D5..D9 = 0), sent from phase 0 after reset, `lock_n` is still 1 after 47 bits and is 0 after the 48th.
- R3: If two or more phases each have four consecutive hits when phase 11 is taken, lock is withheld. Once the pattern changes so that only one phase remains, lock follows at the end of that word.
- R4: While locked, each hit at the locked phase pulses `word_stb` for one cycle, one clock after that bit. With the pulse, `word_out[i]` holds payload bit D_i of the frame that just ended; D0 is the bit that followed that frame's start bit.
- R5: While locked, fewer than four consecutive misses at the locked phase keep the lock, and a hit clears the miss count.
- R6: The fourth consecutive miss at the locked phase sets `lock_n` to 1 one clock after that bit. All phase counts are then cleared and the search restarts.
- R7: `lock_n` is 0 while locked and 1 while searching.
- R8: `out_en` is 1 only when locked, `rx_oe` is 1 and `pwr_dn_n` is 1. While `out_en` is 0, `word_out` is 0 and `word_stb` is 0.
- R9: `rx_oe` low has no effect on lock acquisition, lock holding or `lock_n`.
- R10: While `pwr_dn_n` is 0, every clock clears phase, history, counts and lock. `lock_n` is 1 and serial bits are ignored. After release, the search starts again at phase 0.
- R11: After reset `lock_n` is 1, and `out_en`, `word_stb` and `word_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_in | input | 1 | Recovered serial bit |
| bit_en | input | 1 | Bit-rate enable, one pulse per serial bit |
| rx_oe | input | 1 | Receive output enable, high drives the data path |
| pwr_dn_n | input | 1 | Active-low power-down |
| word_out | output | 10 | Recovered payload word, bit i is D_i |
| word_stb | output | 1 | One-cycle pulse per recovered word |
| lock_n | output | 1 | Active-low lock flag |
| out_en | output | 1 | Output-enable status of word_out and word_stb |

## Verification
The assertions assume that `bit_en` may arrive on any cycle, including back to back, and that `bit_in` matters only when it does. The strobe-spacing property relies on hits at the locked phase coming at least twelve taken bits apart. Both follow from the phase counter alone, for any input stream. The stimulus keeps its words aligned to phase 0 by always sending whole twelve-bit frames or whole-word runs. It toggles `bit_in` during enable gaps, and it changes `rx_oe` and `pwr_dn_n` only between bits. This way each expected lock, unlock and strobe cycle can be counted from the bits sent.

// File: rtl/aligner_pkg.sv
package aligner_pkg;

    // Search / locked state of the aligner
    typedef enum logic {
        ST_SEARCH = 1'b0,
        ST_LOCKED = 1'b1
    } align_state_e;

    // One serial bit event as seen by the downstream logic
    typedef struct packed {
        logic take;   // bit accepted this cycle
        logic bit_v;  // the accepted bit value
        logic hit;    // 0 before, 1 now: candidate boundary
    } bit_evt_t;

    // Index of the highest set bit of a vector (one-hot to binary)
    function automatic int unsigned onehot_index(input logic [31:0] v);
        int unsigned r;
        r = 0;
        for (int i = 0; i < 32; i++) begin
            if (v[i]) r = i;
        end
        return r;
    endfunction

endpackage

// File: rtl/bit_framer.sv
module bit_framer
    import aligner_pkg::*;
#(
    parameter int FRAME_W = 12,
    parameter int PH_W    = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               pwr_ok,
    input  logic               bit_en,
    input  logic               bit_in,
    output logic [PH_W-1:0]    phase_o,
    output logic [FRAME_W-1:0] hist_o,
    output bit_evt_t           evt_o
);
    localparam logic [PH_W-1:0] LAST_PH = PH_W'(FRAME_W - 1);

    logic [PH_W-1:0]    phase_q;
    logic [FRAME_W-1:0] hist_q;

    always_ff @(posedge clk) begin
        if (rst || !pwr_ok) begin
            phase_q <= '0;
            hist_q  <= '0;
        end else if (bit_en) begin
            phase_q <= (phase_q == LAST_PH) ? '0 : phase_q + 1'b1;
            hist_q  <= {hist_q[FRAME_W-2:0], bit_in};
        end
    end

    always_comb begin
        evt_o.take  = bit_en && pwr_ok;
        evt_o.bit_v = bit_in;
        evt_o.hit   = bit_in && !hist_q[0];
    end

    assign phase_o = phase_q;
    assign hist_o  = hist_q;

    p_phase_wrap_r1: assert property (@(posedge clk) disable iff (rst)
        (pwr_ok && bit_en && phase_q == LAST_PH) |=> (phase_q == '0));

    p_idle_holds_r1: assert property (@(posedge clk) disable iff (rst)
        (pwr_ok && !bit_en) |=> $stable(phase_q));

endmodule

// File: rtl/boundary_tracker.sv
module boundary_tracker
    import aligner_pkg::*;
#(
    parameter int FRAME_W  = 12,
    parameter int PH_W     = 4,
    parameter int LOCK_LIM = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clr,
    input  logic            upd,
    input  logic [PH_W-1:0] phase,
    input  logic            hit,
    output logic            cand_unique,
    output logic [PH_W-1:0] cand_pos
);
    localparam int CNT_W = $clog2(LOCK_LIM + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(LOCK_LIM);

    logic [CNT_W-1:0]   cnt_q [FRAME_W];
    logic [CNT_W-1:0]   cnt_d [FRAME_W];
    logic [FRAME_W-1:0] full;

    for (genvar g = 0; g < FRAME_W; g++) begin : g_pos
        always_comb begin
            cnt_d[g] = cnt_q[g];
            if (upd && phase == PH_W'(g)) begin
                if (!hit)                 cnt_d[g] = '0;
                else if (cnt_q[g] != CNT_MAX) cnt_d[g] = cnt_q[g] + 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (rst || clr) cnt_q[g] <= '0;
            else            cnt_q[g] <= cnt_d[g];
        end

        assign full[g] = (cnt_d[g] == CNT_MAX);

        p_miss_clears_r2: assert property (@(posedge clk) disable iff (rst)
            (upd && !clr && phase == PH_W'(g) && !hit) |=> (cnt_q[g] == '0));
    end

    assign cand_unique = ($countones(full) == 1);
    assign cand_pos    = PH_W'(onehot_index(32'(full)));

endmodule

// File: rtl/lock_ctrl.sv
module lock_ctrl
    import aligner_pkg::*;
#(
    parameter int FRAME_W  = 12,
    parameter int PH_W     = 4,
    parameter int MISS_LIM = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            pwr_ok,
    input  bit_evt_t        evt,
    input  logic [PH_W-1:0] phase,
    input  logic            cand_unique,
    input  logic [PH_W-1:0] cand_pos,
    output logic            locked,
    output logic            emit,
    output logic            drop
);
    localparam logic [PH_W-1:0] LAST_PH = PH_W'(FRAME_W - 1);
    localparam int MISS_W = (MISS_LIM > 1) ? $clog2(MISS_LIM) : 1;
    localparam logic [MISS_W-1:0] MISS_TOP = MISS_W'(MISS_LIM - 1);

    align_state_e      state_q;
    logic [PH_W-1:0]   lock_pos_q;
    logic [MISS_W-1:0] miss_q;
    logic              at_pos;

    assign locked = (state_q == ST_LOCKED);
    assign at_pos = (phase == lock_pos_q);
    assign emit   = evt.take && locked && at_pos && evt.hit;
    assign drop   = evt.take && locked && at_pos && !evt.hit && (miss_q == MISS_TOP);

    always_ff @(posedge clk) begin
        if (rst || !pwr_ok) begin
            state_q    <= ST_SEARCH;
            lock_pos_q <= '0;
            miss_q     <= '0;
        end else if (evt.take) begin
            unique case (state_q)
                ST_SEARCH: begin
                    if (phase == LAST_PH && cand_unique) begin
                        state_q    <= ST_LOCKED;
                        lock_pos_q <= cand_pos;
                        miss_q     <= '0;
                    end
                end
                ST_LOCKED: begin
                    if (at_pos) begin
                        if (evt.hit) begin
                            miss_q <= '0;
                        end else if (drop) begin
                            state_q <= ST_SEARCH;
                            miss_q  <= '0;
                        end else begin
                            miss_q <= miss_q + 1'b1;
                        end
                    end
                end
                default: state_q <= ST_SEARCH;
            endcase
        end
    end

    p_no_lock_ambiguous_r3: assert property (@(posedge clk) disable iff (rst)
        (!locked && evt.take && phase == LAST_PH && !cand_unique) |=> !locked);

    p_hold_on_hit_r5: assert property (@(posedge clk) disable iff (rst)
        (pwr_ok && locked && evt.take && at_pos && evt.hit) |=> locked);

    p_drop_on_misses_r6: assert property (@(posedge clk) disable iff (rst)
        (locked && evt.take && at_pos && !evt.hit && miss_q == MISS_TOP) |=> !locked);

endmodule

// File: rtl/word_stage.sv
module word_stage #(
    parameter int DATA_W  = 10,
    parameter int FRAME_W = 12
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               pwr_ok,
    input  logic               emit,
    input  logic [FRAME_W-1:0] hist,
    input  logic               locked,
    input  logic               rx_oe,
    output logic [DATA_W-1:0]  word_out,
    output logic               word_stb,
    output logic               out_en
);
    logic [DATA_W-1:0] word_d;
    logic [DATA_W-1:0] word_q;
    logic              stb_q;

    // hist[0] is the stop bit, hist[DATA_W] is D0 of the frame just ended
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        assign word_d[i] = hist[DATA_W - i];
    end

    always_ff @(posedge clk) begin
        if (rst || !pwr_ok) begin
            word_q <= '0;
            stb_q  <= 1'b0;
        end else begin
            stb_q <= emit;
            if (emit) word_q <= word_d;
        end
    end

    assign out_en   = locked && rx_oe && pwr_ok;
    assign word_out = out_en ? word_q : '0;
    assign word_stb = out_en && stb_q;

    p_stb_single_r4: assert property (@(posedge clk) disable iff (rst)
        stb_q |=> !stb_q);

    p_word_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (pwr_ok && !emit) |=> $stable(word_q));

endmodule

// File: rtl/embedded_word_aligner.sv
module embedded_word_aligner
    import aligner_pkg::*;
#(
    parameter int DATA_W   = 10,
    parameter int LOCK_LIM = 4,
    parameter int MISS_LIM = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_in,
    input  logic              bit_en,
    input  logic              rx_oe,
    input  logic              pwr_dn_n,
    output logic [DATA_W-1:0] word_out,
    output logic              word_stb,
    output logic              lock_n,
    output logic              out_en
);
    localparam int FRAME_W = DATA_W + 2;
    localparam int PH_W    = $clog2(FRAME_W);

    logic               pwr_ok;
    logic [PH_W-1:0]    phase;
    logic [FRAME_W-1:0] hist;
    bit_evt_t           evt;
    logic               cand_unique;
    logic [PH_W-1:0]    cand_pos;
    logic               locked;
    logic               emit;
    logic               drop;

    assign pwr_ok = pwr_dn_n;

    bit_framer #(.FRAME_W(FRAME_W), .PH_W(PH_W)) u_framer (
        .clk(clk), .rst(rst), .pwr_ok(pwr_ok), .bit_en(bit_en), .bit_in(bit_in),
        .phase_o(phase), .hist_o(hist), .evt_o(evt)
    );

    boundary_tracker #(.FRAME_W(FRAME_W), .PH_W(PH_W), .LOCK_LIM(LOCK_LIM)) u_tracker (
        .clk(clk), .rst(rst), .clr(!pwr_ok || drop), .upd(evt.take && !locked),
        .phase(phase), .hit(evt.hit), .cand_unique(cand_unique), .cand_pos(cand_pos)
    );

    lock_ctrl #(.FRAME_W(FRAME_W), .PH_W(PH_W), .MISS_LIM(MISS_LIM)) u_lock (
        .clk(clk), .rst(rst), .pwr_ok(pwr_ok), .evt(evt), .phase(phase),
        .cand_unique(cand_unique), .cand_pos(cand_pos),
        .locked(locked), .emit(emit), .drop(drop)
    );

    word_stage #(.DATA_W(DATA_W), .FRAME_W(FRAME_W)) u_word (
        .clk(clk), .rst(rst), .pwr_ok(pwr_ok), .emit(emit), .hist(hist),
        .locked(locked), .rx_oe(rx_oe),
        .word_out(word_out), .word_stb(word_stb), .out_en(out_en)
    );

    assign lock_n = !locked;

    p_pwrdn_clears_r10: assert property (@(posedge clk) disable iff (rst)
        !pwr_dn_n |=> (lock_n && !out_en && !word_stb));

    p_stb_only_enabled_r8: assert property (@(posedge clk) disable iff (rst)
        (!rx_oe || lock_n) |-> (!word_stb && word_out == '0));

endmodule

// File: tb/embedded_word_aligner_tb.sv
`timescale 1ns/1ps
module embedded_word_aligner_tb;
    localparam logic [9:0] TRAIN = 10'b0000011111;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_in = 1'b0;
    logic       bit_en = 1'b0;
    logic       rx_oe = 1'b1;
    logic       pwr_dn_n = 1'b1;
    logic [9:0] word_out;
    logic       word_stb;
    logic       lock_n;
    logic       out_en;

    int n_chk = 0;
    int n_err = 0;
    logic [9:0] cap [64];
    int ncap = 0;

    always #2 clk = ~clk;

    embedded_word_aligner u_dut (
        .clk(clk), .rst(rst), .bit_in(bit_in), .bit_en(bit_en), .rx_oe(rx_oe),
        .pwr_dn_n(pwr_dn_n), .word_out(word_out), .word_stb(word_stb),
        .lock_n(lock_n), .out_en(out_en)
    );

    // strobe monitor, samples in the middle of the low clock phase
    always begin
        @(negedge clk);
        #1;
        if (word_stb && ncap < 64) begin
            cap[ncap] = word_out;
            ncap++;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    task automatic send_bit(input logic b);
        bit_in = b;
        bit_en = 1'b1;
        @(negedge clk);
        bit_en = 1'b0;
    endtask

    task automatic idle(input int n);
        bit_en = 1'b0;
        for (int k = 0; k < n; k++) begin
            bit_in = ~bit_in;
            @(negedge clk);
        end
    endtask

    task automatic send_frame(input logic [9:0] d, input int gap);
        send_bit(1'b1);
        for (int i = 0; i < 10; i++) begin
            send_bit(d[i]);
            if (gap > 0) idle(gap);
        end
        send_bit(1'b0);
    endtask

    task automatic send_zeros(input int n);
        for (int k = 0; k < n; k++) send_bit(1'b0);
    endtask

    task automatic t_reset();
        chk("R11 lock_n after reset", lock_n, 1);
        chk("R11 out_en after reset", out_en, 0);
        chk("R11 word_stb after reset", word_stb, 0);
        chk("R11 word_out after reset", word_out, 0);
    endtask

    task automatic t_train_lock();
        for (int w = 0; w < 3; w++) send_frame(TRAIN, 0);
        send_bit(1'b1);
        for (int i = 0; i < 10; i++) send_bit(TRAIN[i]);
        chk("R2 no lock after 47 bits", lock_n, 1);
        send_bit(1'b0);
        chk("R2 R7 lock after 48 bits", lock_n, 0);
        chk("R8 out_en when locked", out_en, 1);
    endtask

    task automatic t_data();
        logic [9:0] w [4];
        w[0] = 10'h2A5; w[1] = 10'h13C; w[2] = 10'h3FF; w[3] = 10'h001;
        ncap = 0;
        for (int k = 0; k < 4; k++) send_frame(w[k], k % 3);
        send_frame(TRAIN, 0);
        idle(2);
        chk("R4 strobe count", ncap, 5);
        chk("R4 first word is last training word", cap[0], TRAIN);
        for (int k = 0; k < 4; k++) chk("R4 R1 recovered word", cap[k + 1], w[k]);
    endtask

    task automatic t_oe_off();
        ncap = 0;
        rx_oe = 1'b0;
        for (int k = 0; k < 3; k++) send_frame(TRAIN, 0);
        chk("R8 no strobes with rx_oe low", ncap, 0);
        chk("R8 out_en low with rx_oe low", out_en, 0);
        chk("R8 word_out zero with rx_oe low", word_out, 0);
        chk("R9 lock kept with rx_oe low", lock_n, 0);
        rx_oe = 1'b1;
        send_frame(10'h0C3, 0);
        send_frame(10'h155, 0);
        idle(2);
        chk("R9 strobes resume", ncap, 2);
        chk("R9 word after re-enable", cap[1], 10'h0C3);
    endtask

    task automatic t_miss_hold();
        send_zeros(36);
        chk("R5 locked after three misses", lock_n, 0);
        send_frame(10'h155, 0);
        send_zeros(36);
        chk("R5 miss count cleared by hit", lock_n, 0);
        send_frame(10'h0F0, 0);
    endtask

    task automatic t_unlock();
        send_zeros(36);
        chk("R6 still locked before fourth miss", lock_n, 0);
        send_bit(1'b0);
        chk("R6 R7 unlocked on fourth miss", lock_n, 1);
        chk("R8 out_en low after unlock", out_en, 0);
        send_zeros(11);
    endtask

    task automatic t_rmt();
        for (int k = 0; k < 8; k++) send_frame(10'b0000000010, 0);
        chk("R3 ambiguous pattern withheld", lock_n, 1);
        send_bit(1'b1);
        for (int i = 0; i < 10; i++) send_bit(TRAIN[i]);
        chk("R3 no lock mid word", lock_n, 1);
        send_bit(1'b0);
        chk("R3 lock once pattern changes", lock_n, 0);
    endtask

    task automatic t_pwrdn();
        ncap = 0;
        @(negedge clk);
        pwr_dn_n = 1'b0;
        @(negedge clk);
        chk("R10 lock_n high in power-down", lock_n, 1);
        for (int k = 0; k < 5; k++) send_frame(TRAIN, 0);
        chk("R10 bits ignored in power-down", lock_n, 1);
        chk("R10 out_en low in power-down", out_en, 0);
        chk("R10 no strobes in power-down", ncap, 0);
        pwr_dn_n = 1'b1;
        for (int k = 0; k < 3; k++) send_frame(TRAIN, 0);
        send_bit(1'b1);
        for (int i = 0; i < 10; i++) send_bit(TRAIN[i]);
        chk("R10 search restarts at phase 0", lock_n, 1);
        send_bit(1'b0);
        chk("R10 relock after release", lock_n, 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_train_lock();
        t_data();
        t_oe_off();
        t_miss_hold();
        t_unlock();
        t_rmt();
        t_pwrdn();
        idle(4);
        summary();
    end

endmodule